// File: doc/BRIEF.md
# GPIO Interrupt and Wake Event Detector

This block watches a vector of already-synchronised GPIO pin levels. Each pin has its own event detector and can look for a rising edge, a falling edge, both edges, or a high or low level. A glitch filter sits ahead of each detector and can be skipped per pin. A detected event latches into a sticky interrupt source bit and, in parallel, into a sticky wake source bit. Software clears both kinds of bit by writing ones.

Two mask registers then reduce the sources to two outputs. The interrupt output is raised while any enabled interrupt source is pending. The wake output is raised while any enabled wake source is pending. The block is configured over a simple register bus that offers a one-cycle write strobe and a read path that decodes the address combinationally. Pin data and pin direction belong to other logic.

All pins and the bus are control and status signals. There is no streamed data, so no port uses a valid/ready handshake and there is no back-pressure. A write takes effect at the clock edge where `reg_we` is high. Read data follows `reg_addr` within the same cycle.

Top module: `gpio_irq_wake`

## Requirements
- R1: After reset every configuration register and both source registers read 0, and `irq_o` and `wake_o` are 0.
- R2: In edge mode, a pin whose bit is set in the rising-edge enable register (offset 0x064) latches its source bit on a 0-to-1 change. A pin whose bit is set in the falling-edge enable register (offset 0x07C) latches on a 1-to-0 change. With both bits set, both changes latch. With neither bit set, changes are ignored.
- R3: A 1 in the input-type register (offset 0x318 holds polarity, 0x300 holds type) selects level mode for that pin. A polarity bit of 1 makes low the active level and 0 makes high the active level. While the active level is present, the source bit is set again on every clock, so a clear has no lasting effect until the level goes away.
- R4: A 1 in the filter-bypass register (offset 0x094) feeds the pin straight to its detector, and a bypassed edge is latched at the first clock that samples it. A 0 routes the pin through a filter that passes a new value only after 3 consecutive equal samples, so the event is latched one clock later than that. A pulse lasting 2 samples is rejected.
- R5: Writing the interrupt source register (offset 0x0C4) clears each bit written as 1. Bits written as 0 are left unchanged.
- R6: When a source bit is cleared in the same cycle as a new event on that pin, the event wins and the bit stays 1.
- R7: `irq_o` is 1 exactly when some bit is set both in the interrupt source register and in the interrupt mask register (offset 0x0AC, 1 = enabled). A masked event is still latched as a source.
- R8: Every detected event also sets the wake source register (offset 0x418), which is cleared by writing 1s independently of the interrupt sources. `wake_o` is the OR of the wake sources ANDed with the wake mask (offset 0x400).
- R9: Each configuration register reads back the last value written at its offset. Bit i of every register belongs to pin i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPIN | Synchronised pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | NPIN | Write data, one bit per pin |
| reg_rdata | output | NPIN | Read data for the register at `reg_addr` |
| irq_o | output | 1 | Combined masked interrupt request |
| wake_o | output | 1 | Combined masked wake request |

## Verification
The hardest case to reach from the ports is a write-one clear that lands in exactly the same clock as a fresh edge on the same pin. The stimulus reaches it by driving the pin change and the clearing write in one cycle, so that both are sampled at the same edge. The filter threshold is also delicate. It is probed with a pulse one sample too short, and then with a steady level whose latch cycle is checked on both sides of the expected edge. Level mode is exercised by clearing a bit while its level is still present, and again after the level has gone away.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int ADDR_W = 12;
  localparam int NCFG   = 7;

  localparam int CFG_RISE  = 0;
  localparam int CFG_FALL  = 1;
  localparam int CFG_BYP   = 2;
  localparam int CFG_MASK  = 3;
  localparam int CFG_TYPE  = 4;
  localparam int CFG_POL   = 5;
  localparam int CFG_WMASK = 6;

  localparam logic [ADDR_W-1:0] CFG_OFFS [NCFG] = '{
    12'h064, 12'h07C, 12'h094, 12'h0AC, 12'h300, 12'h318, 12'h400
  };
  localparam logic [ADDR_W-1:0] ISRC_OFFS = 12'h0C4;
  localparam logic [ADDR_W-1:0] WSRC_OFFS = 12'h418;
endpackage

// File: rtl/gpio_cfg_reg.sv
`timescale 1ns/1ps
module gpio_cfg_reg
  import gpio_irq_pkg::*;
#(
  parameter int W = 8,
  parameter logic [ADDR_W-1:0] OFFS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    q <= '0;
    else if (we && addr == OFFS)   q <= wdata;
  end
endmodule

// File: rtl/gpio_glitch_filter.sv
`timescale 1ns/1ps
module gpio_glitch_filter #(
  parameter int STABLE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int CW = (STABLE > 2) ? $clog2(STABLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (d == q) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      q   <= d;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_event_detect.sv
`timescale 1ns/1ps
module gpio_event_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic filt,
  input  logic bypass,
  input  logic rise_en,
  input  logic fall_en,
  input  logic lvl_mode,
  input  logic act_low,
  output logic ev
);
  logic cur, prev;

  assign cur = bypass ? raw : filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= cur;
  end

  always_comb begin
    if (lvl_mode) ev = cur ^ act_low;
    else          ev = (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
  end
endmodule

// File: rtl/gpio_sticky_bank.sv
`timescale 1ns/1ps
module gpio_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/gpio_irq_wake.sv
`timescale 1ns/1ps
module gpio_irq_wake
  import gpio_irq_pkg::*;
#(
  parameter int NPIN     = 8,
  parameter int FILT_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPIN-1:0]   reg_wdata,
  output logic [NPIN-1:0]   reg_rdata,
  output logic              irq_o,
  output logic              wake_o
);
  logic [NPIN-1:0] cfg [NCFG];
  logic [NPIN-1:0] filt_vec, ev_vec;
  logic [NPIN-1:0] isrc_clr, wsrc_clr;
  logic [NPIN-1:0] isrc_q, wsrc_q;

  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    gpio_cfg_reg #(.W(NPIN), .OFFS(CFG_OFFS[k])) u_reg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .q(cfg[k])
    );
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpio_glitch_filter #(.STABLE(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .d(pin_i[i]), .q(filt_vec[i])
    );
    gpio_event_detect u_det (
      .clk(clk), .rst_n(rst_n),
      .raw(pin_i[i]), .filt(filt_vec[i]),
      .bypass(cfg[CFG_BYP][i]),
      .rise_en(cfg[CFG_RISE][i]), .fall_en(cfg[CFG_FALL][i]),
      .lvl_mode(cfg[CFG_TYPE][i]), .act_low(cfg[CFG_POL][i]),
      .ev(ev_vec[i])
    );
  end

  assign isrc_clr = (reg_we && reg_addr == ISRC_OFFS) ? reg_wdata : '0;
  assign wsrc_clr = (reg_we && reg_addr == WSRC_OFFS) ? reg_wdata : '0;

  gpio_sticky_bank #(.W(NPIN)) u_isrc (
    .clk(clk), .rst_n(rst_n), .set(ev_vec), .clr(isrc_clr), .q(isrc_q)
  );
  gpio_sticky_bank #(.W(NPIN)) u_wsrc (
    .clk(clk), .rst_n(rst_n), .set(ev_vec), .clr(wsrc_clr), .q(wsrc_q)
  );

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NCFG; k++)
      if (reg_addr == CFG_OFFS[k]) reg_rdata = cfg[k];
    if (reg_addr == ISRC_OFFS) reg_rdata = isrc_q;
    if (reg_addr == WSRC_OFFS) reg_rdata = wsrc_q;
  end

  assign irq_o  = |(isrc_q & cfg[CFG_MASK]);
  assign wake_o = |(wsrc_q & cfg[CFG_WMASK]);
endmodule

// File: rtl/gpio_irq_wake_chk.sv
`timescale 1ns/1ps
module gpio_irq_wake_chk #(
  parameter int NPIN     = 8,
  parameter int FILT_LEN = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] pin_i,
  input logic [NPIN-1:0] filt,
  input logic [NPIN-1:0] ev,
  input logic [NPIN-1:0] isrc_clr,
  input logic [NPIN-1:0] isrc,
  input logic [NPIN-1:0] wsrc,
  input logic            irq,
  input logic            wake
);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((isrc & $past(ev)) == $past(ev)));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((isrc & $past(isrc_clr & ~ev)) == '0));

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((isrc & ~$past(isrc) & ~$past(ev)) == '0));

  // R7
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isrc == '0) |-> !irq);

  // R8
  wake_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wsrc == '0) |-> !wake);

  // R8
  wake_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((wsrc & $past(ev)) == $past(ev)));

  if (FILT_LEN >= 3) begin : g_filt_chk
    // R4
    filter_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((filt ^ $past(filt)) &
                 ((filt ^ $past(pin_i, 1)) | (filt ^ $past(pin_i, 2)) |
                  (filt ^ $past(pin_i, 3)))) == '0));
  end
endmodule

bind gpio_irq_wake gpio_irq_wake_chk #(.NPIN(NPIN), .FILT_LEN(FILT_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .filt(filt_vec), .ev(ev_vec),
  .isrc_clr(isrc_clr), .isrc(isrc_q), .wsrc(wsrc_q),
  .irq(irq_o), .wake(wake_o)
);

// File: tb/tb_gpio_irq_wake.sv
`timescale 1ns/1ps
module tb_gpio_irq_wake;
  import gpio_irq_pkg::*;
  localparam int NPIN = 8;
  localparam int FL   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NPIN-1:0]   pins = '0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = ISRC_OFFS;
  logic [NPIN-1:0]   wdata = '0;
  logic [NPIN-1:0]   rdata;
  logic              irq, wake;

  always #10 clk = ~clk;

  gpio_irq_wake #(.NPIN(NPIN), .FILT_LEN(FL)) dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq), .wake_o(wake)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [NPIN-1:0] m_cfg [NCFG];
  logic [NPIN-1:0] m_src, m_wsrc, m_filt, m_prev;
  int m_cnt [NPIN];

  always @(posedge clk) begin : model
    logic [NPIN-1:0] sel, ev;
    if (!rst_n) begin
      for (int k = 0; k < NCFG; k++) m_cfg[k] = '0;
      m_src = '0; m_wsrc = '0; m_filt = '0; m_prev = '0;
      for (int i = 0; i < NPIN; i++) m_cnt[i] = 0;
    end else begin
      for (int i = 0; i < NPIN; i++) begin
        sel[i] = m_cfg[CFG_BYP][i] ? pins[i] : m_filt[i];
        if (m_cfg[CFG_TYPE][i]) ev[i] = sel[i] ^ m_cfg[CFG_POL][i];
        else ev[i] = (m_cfg[CFG_RISE][i] && sel[i] && !m_prev[i]) ||
                     (m_cfg[CFG_FALL][i] && !sel[i] && m_prev[i]);
      end
      if (we && addr == ISRC_OFFS) m_src  = m_src  & ~wdata;
      if (we && addr == WSRC_OFFS) m_wsrc = m_wsrc & ~wdata;
      m_src  = m_src  | ev;
      m_wsrc = m_wsrc | ev;
      for (int i = 0; i < NPIN; i++) begin
        if (pins[i] == m_filt[i]) m_cnt[i] = 0;
        else if (m_cnt[i] == FL - 1) begin m_filt[i] = pins[i]; m_cnt[i] = 0; end
        else m_cnt[i] = m_cnt[i] + 1;
      end
      m_prev = sel;
      if (we)
        for (int k = 0; k < NCFG; k++)
          if (addr == CFG_OFFS[k]) m_cfg[k] = wdata;
    end
  end

  function automatic logic [NPIN-1:0] m_read(input logic [ADDR_W-1:0] a);
    logic [NPIN-1:0] r = '0;
    for (int k = 0; k < NCFG; k++) if (a == CFG_OFFS[k]) r = m_cfg[k];
    if (a == ISRC_OFFS) r = m_src;
    if (a == WSRC_OFFS) r = m_wsrc;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 per-cycle irq", NPIN'(irq), NPIN'(|(m_src & m_cfg[CFG_MASK])));
      chk("R8 per-cycle wake", NPIN'(wake), NPIN'(|(m_wsrc & m_cfg[CFG_WMASK])));
      chk("R9 per-cycle read", rdata, m_read(addr));
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [NPIN-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0; addr = ISRC_OFFS; wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [NPIN-1:0] exp, input string tag);
    addr = a; #1;
    chk(tag, rdata, exp);
    addr = ISRC_OFFS;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    // R1 reset state
    rd(ISRC_OFFS, 8'h00, "R1 source after reset");
    rd(WSRC_OFFS, 8'h00, "R1 wake source after reset");
    rd(12'h064, 8'h00, "R1 rise enable after reset");
    rd(12'h300, 8'h00, "R1 type after reset");
    chk("R1 irq after reset", NPIN'(irq), 8'h00);
    chk("R1 wake after reset", NPIN'(wake), 8'h00);
    // R9 configuration
    wr(12'h064, 8'h05); wr(12'h07C, 8'h06); wr(12'h094, 8'hDF); wr(12'h0AC, 8'hFF);
    rd(12'h064, 8'h05, "R9 rise readback");
    rd(12'h07C, 8'h06, "R9 fall readback");
    rd(12'h094, 8'hDF, "R9 bypass readback");
    // R2 edges (R4 bypassed pin latches at first sample)
    pins = 8'h01; step(); rd(ISRC_OFFS, 8'h01, "R2 R4 bypassed rise");
    chk("R7 irq on enabled source", NPIN'(irq), 8'h01);
    pins = 8'h03; step(); rd(ISRC_OFFS, 8'h01, "R2 rise ignored on fall-only pin");
    pins = 8'h01; step(); rd(ISRC_OFFS, 8'h03, "R2 fall latched");
    pins = 8'h05; step(); rd(ISRC_OFFS, 8'h07, "R2 both-edge rise");
    wr(ISRC_OFFS, 8'h04); rd(ISRC_OFFS, 8'h03, "R5 single bit clear");
    pins = 8'h01; step(); rd(ISRC_OFFS, 8'h07, "R2 both-edge fall");
    chk("R8 wake masked off", NPIN'(wake), 8'h00);
    rd(WSRC_OFFS, 8'h07, "R8 wake sources captured");
    // R5 write-one-to-clear
    wr(ISRC_OFFS, 8'h00); rd(ISRC_OFFS, 8'h07, "R5 zero write no effect");
    wr(ISRC_OFFS, 8'h02); rd(ISRC_OFFS, 8'h05, "R5 clear bit1");
    wr(ISRC_OFFS, 8'hFF); rd(ISRC_OFFS, 8'h00, "R5 clear all");
    chk("R7 irq low when empty", NPIN'(irq), 8'h00);
    // R6 set beats clear
    pins = 8'h00; step(); rd(ISRC_OFFS, 8'h00, "R2 disabled fall ignored");
    pins = 8'h01; we = 1'b1; addr = ISRC_OFFS; wdata = 8'h01;
    step();
    we = 1'b0; wdata = '0;
    rd(ISRC_OFFS, 8'h01, "R6 event wins over clear");
    wr(ISRC_OFFS, 8'hFF);
    // R7 mask
    wr(12'h0AC, 8'h02);
    pins = 8'h00; step();
    pins = 8'h01; step(); rd(ISRC_OFFS, 8'h01, "R7 masked event still latched");
    chk("R7 masked source no irq", NPIN'(irq), 8'h00);
    wr(12'h0AC, 8'h03);
    chk("R7 unmask raises irq", NPIN'(irq), 8'h01);
    wr(ISRC_OFFS, 8'hFF);
    // R3 level mode
    wr(12'h318, 8'h10); wr(12'h300, 8'h18);
    rd(12'h300, 8'h18, "R9 type readback");
    step(); rd(ISRC_OFFS, 8'h10, "R3 active-low level latched");
    wr(ISRC_OFFS, 8'h10); rd(ISRC_OFFS, 8'h10, "R3 clear while level present");
    pins = 8'h19; step(); rd(ISRC_OFFS, 8'h18, "R3 active-high level latched");
    wr(ISRC_OFFS, 8'h18); rd(ISRC_OFFS, 8'h08, "R3 only inactive pin clears");
    pins = 8'h11; step(); rd(ISRC_OFFS, 8'h08, "R3 bit held after level gone");
    wr(ISRC_OFFS, 8'h08); rd(ISRC_OFFS, 8'h00, "R3 clear after level gone");
    wr(12'h300, 8'h00); wr(ISRC_OFFS, 8'hFF);
    rd(ISRC_OFFS, 8'h00, "R3 back to edge mode idle");
    // R4 glitch filter on pin5
    wr(12'h064, 8'h25);
    pins = 8'h31; step(); step();
    pins = 8'h11; step(); step();
    rd(ISRC_OFFS, 8'h00, "R4 two-sample pulse rejected");
    pins = 8'h31; step(); step(); step();
    rd(ISRC_OFFS, 8'h00, "R4 not latched before filter passes");
    step(); rd(ISRC_OFFS, 8'h20, "R4 latched after three samples");
    // R8 wake path
    wr(WSRC_OFFS, 8'hFF); wr(ISRC_OFFS, 8'hFF);
    chk("R8 wake low after clear", NPIN'(wake), 8'h00);
    wr(12'h400, 8'h01);
    pins = 8'h30; step();
    pins = 8'h31; step();
    rd(WSRC_OFFS, 8'h01, "R8 wake source set");
    chk("R8 wake raised", NPIN'(wake), 8'h01);
    wr(WSRC_OFFS, 8'h01);
    chk("R8 wake cleared", NPIN'(wake), 8'h00);
    rd(ISRC_OFFS, 8'h01, "R8 interrupt source independent");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule